// File: doc/BRIEF.md
# Dual-Channel Split-Duration PWM Generator

This block drives two independent pulse-width-modulated outputs. Each channel is programmed with a high duration and a low duration, both counted in prescaled ticks, so the period is the sum of the two. Both values are packed into one 32-bit word per channel.

Both channels share one control word. For each channel it holds an output enable, a counter clock enable, a 2-bit selector that picks one of four incoming tick strobes, and a 7-bit prescaler. The tick strobes are clock enables in the block's own clock domain. They stand in for the slower source clocks the outputs are derived from.

Software reaches the registers through a simple bus that completes in one cycle. A write lands on the next rising edge. Read data is a combinational function of the address.

Top module: `twin_pwm_gen`

## Requirements
- R1: After reset, every register reads zero and both outputs are low.
- R2: The channel 0 duty word is at byte address 0x0 and the channel 1 duty word is at 0x4. Each word holds the high count in bits [31:16] and the low count in bits [15:0], and reads back exactly as written.
- R3: The shared control word is at 0x8. It has the following fields:
  - output enables: bit 0 for channel 0 and bit 1 for channel 1;
  - source selects: [5:4] for channel 0 and [7:6] for channel 1;
  - prescalers: [14:8] for channel 0 and [22:16] for channel 1;
  - counter clock enables: bit 15 for channel 0 and bit 23 for channel 1.

  All other bits read as zero, so writing all ones reads back 0x00FFFFF3.
- R4: A channel counts only on the tick strobe picked by its select field. Input `src_tick[4*c + sel]` feeds channel c.
- R5: The prescaler passes one counting step for every (field + 1) selected ticks, which gives a division of 1 to 128.
- R6: Each high phase lasts exactly the high count in steps, and each low phase lasts exactly the low count. One period equals the high count plus the low count.
- R7: A high count of zero keeps the output constantly low. A low count of zero with a nonzero high count keeps it constantly high.
- R8: Counting advances only while both the output enable and the counter clock enable of that channel are set. With the clock enable clear, the output holds its level.
- R9: A duty word that is written takes effect only at the next period boundary, which is the end of a low phase. A write that lands on the very edge of a boundary is first used at the boundary after that.
- R10: Clearing the output enable forces the output low on the next cycle and restarts the period. Setting it again starts with the high phase, using the duty word then held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| src_tick | input | 8 | Four tick strobes per channel, channel c at [4c+3:4c] |
| pwm_out | output | 2 | PWM output, bit c for channel c |

## Verification
Two events can land on the same clock edge: a software write to a duty word and the period wrap that reloads the channel's working copy of that word. The bench provokes this on purpose. It watches its own reference model, waits for the cycle in which the position is at the last step of a period, and then issues the write so that it lands exactly on the wrap edge. The cycle model expects the old durations to run for one more full period. A direct count of high cycles over the following period confirms this. Every other cycle of the run is compared against the same model on both outputs, while sources, prescalers and enables change.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;

    localparam int NCH    = 2;
    localparam int NSRC   = 4;
    localparam int SEL_W  = $clog2(NSRC);
    localparam int DIV_W  = 7;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 2 * CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } duty_t;

    typedef struct packed {
        logic             clk_en;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
        logic             out_en;
    } chan_cfg_t;

    function automatic int en_bit(input int c);
        return c;
    endfunction

    function automatic int sel_lsb(input int c);
        return 4 + SEL_W * c;
    endfunction

    function automatic int div_lsb(input int c);
        return 8 + 8 * c;
    endfunction

    function automatic int cke_bit(input int c);
        return div_lsb(c) + DIV_W;
    endfunction

endpackage

// File: rtl/twin_pwm_regs.sv
module twin_pwm_regs
    import twin_pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output duty_t     [NCH-1:0]       duty_q,
    output chan_cfg_t [NCH-1:0]       cfg_q
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             unused_bits;

    assign idx         = addr[ADDR_W-1:2];
    assign unused_bits = ^{addr[1:0], wdata[3:2], wdata[DATA_W-1:24]};

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
            cfg_q  <= '0;
        end else if (we) begin
            for (int c = 0; c < NCH; c++) begin
                if (idx == IDX_W'(c)) duty_q[c] <= duty_t'(wdata);
            end
            if (idx == IDX_W'(NCH)) begin
                for (int c = 0; c < NCH; c++) begin
                    cfg_q[c].out_en <= wdata[en_bit(c)];
                    cfg_q[c].sel    <= wdata[sel_lsb(c) +: SEL_W];
                    cfg_q[c].div    <= wdata[div_lsb(c) +: DIV_W];
                    cfg_q[c].clk_en <= wdata[cke_bit(c)];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (idx == IDX_W'(c)) rdata = duty_q[c];
        end
        if (idx == IDX_W'(NCH)) begin
            for (int c = 0; c < NCH; c++) begin
                rdata[en_bit(c)]             = cfg_q[c].out_en;
                rdata[sel_lsb(c) +: SEL_W]   = cfg_q[c].sel;
                rdata[div_lsb(c) +: DIV_W]   = cfg_q[c].div;
                rdata[cke_bit(c)]            = cfg_q[c].clk_en;
            end
        end
    end

endmodule

// File: rtl/twin_pwm_presc.sv
module twin_pwm_presc
    import twin_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div,
    output logic             step
);
    logic [DIV_W-1:0] pcnt;
    logic             sel_tick;
    logic             at_top;

    assign sel_tick = src_tick[sel];
    // ">=" keeps the count bounded when the divider shrinks mid-count
    assign at_top   = (pcnt >= div);
    assign step     = run && sel_tick && at_top;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
        end else if (sel_tick) begin
            pcnt <= at_top ? '0 : pcnt + 1'b1;
        end
    end

    // R5: an idle prescaler restarts its division from zero
    a_r5_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pcnt == '0));

endmodule

// File: rtl/twin_pwm_phase.sv
module twin_pwm_phase
    import twin_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  step,
    input  duty_t duty_in,
    output logic  pwm
);
    logic [CNT_W-1:0] hi_act;
    logic [CNT_W-1:0] lo_act;
    logic [CNT_W:0]   pos;
    logic [CNT_W:0]   pos_inc;
    logic [CNT_W:0]   span;
    logic             wrap;

    assign span    = {1'b0, hi_act} + {1'b0, lo_act};
    assign pos_inc = pos + 1'b1;
    assign wrap    = step && (pos_inc >= span);
    assign pwm     = en && ({1'b0, hi_act} > pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            hi_act <= '0;
            lo_act <= '0;
        end else if (!en) begin
            pos    <= '0;
            hi_act <= duty_in.hi;
            lo_act <= duty_in.lo;
        end else if (step) begin
            if (wrap) begin
                pos    <= '0;
                hi_act <= duty_in.hi;
                lo_act <= duty_in.lo;
            end else begin
                pos <= pos_inc;
            end
        end
    end

    // R10: a disabled channel restarts its period at position zero
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pos == '0));

    // R8: without a counting step the position holds
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (en && !step) |=> $stable(pos));

    // R9: working durations change only at a period boundary
    a_r9_boundary_only: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap) |=> ($stable(hi_act) && $stable(lo_act)));

    // R6: the position never leaves the current period
    a_r6_pos_range: assert property (@(posedge clk) disable iff (rst)
        (span != '0) |-> (pos < span));

endmodule

// File: rtl/twin_pwm_gen.sv
module twin_pwm_gen
    import twin_pwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NCH*NSRC-1:0]  src_tick,
    output logic [NCH-1:0]       pwm_out
);
    duty_t     [NCH-1:0] duty_q;
    chan_cfg_t [NCH-1:0] cfg_q;

    twin_pwm_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .duty_q (duty_q),
        .cfg_q  (cfg_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic run;
        logic step;

        assign run = cfg_q[c].out_en && cfg_q[c].clk_en;

        twin_pwm_presc presc_i (
            .clk      (clk),
            .rst      (rst),
            .run      (run),
            .src_tick (src_tick[c*NSRC +: NSRC]),
            .sel      (cfg_q[c].sel),
            .div      (cfg_q[c].div),
            .step     (step)
        );

        twin_pwm_phase phase_i (
            .clk     (clk),
            .rst     (rst),
            .en      (cfg_q[c].out_en),
            .step    (step),
            .duty_in (duty_q[c]),
            .pwm     (pwm_out[c])
        );
    end

endmodule

// File: tb/twin_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module twin_pwm_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  src_tick = '0;
    logic [1:0]  pwm_out;

    int    checks = 0;
    int    errs = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    localparam logic [31:0] B_CFG = 32'h0081_00C2; // ch1: en, sel 3, div 1, clk_en

    always #2.5 clk = ~clk;

    twin_pwm_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_tick  (src_tick),
        .pwm_out   (pwm_out)
    );

    // behavioural reference model
    logic [31:0] m_duty [2];
    logic [31:0] m_ctrl;
    int          m_pcnt [2];
    int          m_pos  [2];
    int          m_hi   [2];
    int          m_lo   [2];

    function automatic bit exp_out(input int c);
        return ((m_ctrl >> c) & 1) != 0 && (m_pos[c] < m_hi[c]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = '0;
            for (int c = 0; c < 2; c++) begin
                m_duty[c] = '0; m_pcnt[c] = 0; m_pos[c] = 0;
                m_hi[c] = 0; m_lo[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                int  sel, dv;
                bit  en, ce, tk, stp;
                en  = ((m_ctrl >> c) & 1) != 0;
                ce  = ((m_ctrl >> (15 + 8*c)) & 1) != 0;
                sel = int'((m_ctrl >> (4 + 2*c)) & 3);
                dv  = int'((m_ctrl >> (8 + 8*c)) & 127);
                tk  = src_tick[4*c + sel];
                stp = en && ce && tk && (m_pcnt[c] >= dv);
                if (!(en && ce)) m_pcnt[c] = 0;
                else if (tk) m_pcnt[c] = (m_pcnt[c] >= dv) ? 0 : m_pcnt[c] + 1;
                if (!en) begin
                    m_pos[c] = 0;
                    m_hi[c] = int'(m_duty[c] >> 16);
                    m_lo[c] = int'(m_duty[c] & 32'hFFFF);
                end else if (stp) begin
                    if (m_pos[c] + 1 >= m_hi[c] + m_lo[c]) begin
                        m_pos[c] = 0;
                        m_hi[c] = int'(m_duty[c] >> 16);
                        m_lo[c] = int'(m_duty[c] & 32'hFFFF);
                    end else begin
                        m_pos[c] = m_pos[c] + 1;
                    end
                end
            end
            if (bus_we) begin
                case (bus_addr[3:2])
                    2'd0: m_duty[0] = bus_wdata;
                    2'd1: m_duty[1] = bus_wdata;
                    2'd2: m_ctrl = bus_wdata & 32'h00FF_FFF3;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            for (int c = 0; c < 2; c++)
                chk(pwm_out[c] == exp_out(c), cur_req, 32'(pwm_out[c]), 32'(exp_out(c)));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #0.5;
        chk(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic count_high(input int c, input int n, output int k);
        k = 0;
        repeat (n) begin
            @(negedge clk);
            k += int'(pwm_out[c]);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            chk(1'b0, "watchdog", 32'h0, 32'h1);
            summary();
            $finish;
        end
    end

    initial begin
        int k;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp_on = 1'b1;

        // R1: reset state
        cur_req = "R1";
        rd_chk(4'h0, 32'h0, "R1");
        rd_chk(4'h4, 32'h0, "R1");
        rd_chk(4'h8, 32'h0, "R1");
        chk(pwm_out == 2'b00, "R1", 32'(pwm_out), 32'h0);

        // R2 / R3: register layout
        cur_req = "R2";
        wr(4'h0, 32'h0003_0005);
        wr(4'h4, 32'h0002_0002);
        rd_chk(4'h0, 32'h0003_0005, "R2");
        rd_chk(4'h4, 32'h0002_0002, "R2");
        cur_req = "R3";
        wr(4'h8, 32'hFFFF_FFFF);
        rd_chk(4'h8, 32'h00FF_FFF3, "R3");
        wr(4'h8, 32'h0);
        rd_chk(4'h8, 32'h0, "R3");

        // R6: hi 3, lo 5, div 0, every tick active
        cur_req = "R6";
        src_tick = 8'hFF;
        wr(4'h8, B_CFG | 32'h8001);
        rd_chk(4'h8, B_CFG | 32'h8001, "R3");
        repeat (10) @(negedge clk);
        count_high(0, 16, k);
        chk(k == 6, "R6", 32'(k), 32'd6);
        count_high(1, 16, k);
        chk(k == 8, "R6", 32'(k), 32'd8);

        // R5: prescaler field 2 -> divide by 3
        cur_req = "R5";
        wr(4'h8, B_CFG | 32'h8201);
        repeat (30) @(negedge clk);
        count_high(0, 48, k);
        chk(k == 18, "R5", 32'(k), 32'd18);

        // R4: select source 2, only that strobe active
        cur_req = "R4";
        src_tick = 8'hF4;
        wr(4'h8, B_CFG | 32'h8021);
        repeat (10) @(negedge clk);
        count_high(0, 16, k);
        chk(k == 6, "R4", 32'(k), 32'd6);
        wr(4'h8, B_CFG | 32'h8011);
        repeat (2) @(negedge clk);
        count_high(0, 16, k);
        chk(k == 0 || k == 16, "R4", 32'(k), 32'd0);
        src_tick = 8'hFF;

        // R7: zero high count, then zero low count
        cur_req = "R7";
        wr(4'h0, 32'h0000_0004);
        wr(4'h8, B_CFG);
        wr(4'h8, B_CFG | 32'h8001);
        count_high(0, 16, k);
        chk(k == 0, "R7", 32'(k), 32'd0);
        wr(4'h0, 32'h0004_0000);
        wr(4'h8, B_CFG);
        wr(4'h8, B_CFG | 32'h8001);
        count_high(0, 16, k);
        chk(k == 16, "R7", 32'(k), 32'd16);

        // R8: one enable alone does not count
        cur_req = "R8";
        wr(4'h0, 32'h0003_0005);
        wr(4'h8, B_CFG);
        wr(4'h8, B_CFG | 32'h0001);
        count_high(0, 16, k);
        chk(k == 16, "R8", 32'(k), 32'd16);
        wr(4'h8, B_CFG | 32'h8000);
        count_high(0, 16, k);
        chk(k == 0, "R8", 32'(k), 32'd0);

        // R9: write landing exactly on the wrap edge
        cur_req = "R9";
        wr(4'h8, B_CFG | 32'h8001);
        @(negedge clk);
        while (m_pos[0] != 7) @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h0001_0001;
        @(negedge clk);
        bus_we = 1'b0;
        k = int'(pwm_out[0]);
        repeat (7) begin
            @(negedge clk);
            k += int'(pwm_out[0]);
        end
        chk(k == 3, "R9", 32'(k), 32'd3);
        count_high(0, 16, k);
        chk(k == 8, "R9", 32'(k), 32'd8);

        // R10: disable forces low, re-enable starts high
        cur_req = "R10";
        wr(4'h8, B_CFG);
        chk(pwm_out[0] == 1'b0, "R10", 32'(pwm_out[0]), 32'd0);
        wr(4'h8, B_CFG | 32'h8001);
        chk(pwm_out[0] == 1'b1, "R10", 32'(pwm_out[0]), 32'd1);
        repeat (20) @(negedge clk);

        cmp_on = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule